// File: doc/BRIEF.md
# Dual-Issue Pair Checker

This block stands between a 64-bit fetch stage and the two issue ports of an in-order, two-wide pipeline. One port feeds the integer/other pipe and the other feeds the floating-point pipe. Each accepted fetch word holds two 32-bit instructions. The lower half is the older one and the upper half is the younger one. The block latches the pair and decodes the class and the three register specifiers of each instruction. It then decides whether the pair can go out together, whether only the older one goes, or whether nothing goes.

A pair issues together only in one case. The older instruction must be non-FP and the younger one FP, the younger instruction must not touch the older one's destination, and neither may read a busy register. In every other case the older instruction issues alone and the younger one is held. The held instruction is evaluated alone on the following cycle. Register dependences on instructions already in the pipes come in as a per-register busy vector. Fetch sees a valid/ready handshake, and ready stays low until every latched instruction has left.

Instruction fields: bit 31 is the class (1 = FP), bits 30:26 are the operation, bits 25:21 are the destination, bits 20:16 are the first source, and bits 15:11 are the second source. Every instruction writes its destination and reads both sources.

Top module: `dual_issue_pair`

## Requirements
- R1: In the first cycle after reset neither port issues, hold is low and fetch_ready is high.
- R2: A fetch word is taken on a clock edge with fetch_valid and fetch_ready both high. Bits 31:0 are the older instruction and bits 63:32 the younger one. Its instructions can issue from the cycle after that edge, and the issued word appears unchanged on the port that carries it.
- R3: An instruction with bit 31 clear issues only on the integer port, and one with bit 31 set issues only on the FP port.
- R4: Both instructions issue in the same cycle when four conditions hold: the older one has bit 31 clear, the younger one has bit 31 set, the younger one's destination and both sources differ from the older one's destination (bits 25:21), and no source of either is busy.
- R5: When the class placement is anything other than older non-FP with younger FP, only the older instruction issues that cycle.
- R6: When a source or the destination of the younger instruction equals the destination of the older one, only the older instruction issues.
- R7: The younger instruction of a pair never issues before or without the older one in the same cycle.
- R8: An instruction with a busy bit set for either of its source registers does not issue. If the older one is blocked, nothing issues.
- R9: hold is high in exactly the cycles where the older instruction issues and the younger one stays. The held instruction issues alone on its own port in the first later cycle in which its sources are free.
- R10: fetch_ready is high only when no latched instruction will remain after the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch word present |
| fetch_word | input | 64 | Two instructions, older in the low half |
| fetch_ready | output | 1 | Block can take a fetch word this cycle |
| reg_busy | input | 32 | One bit per register, set while a write to it is pending |
| int_issue | output | 1 | Integer/other port issues this cycle |
| int_instr | output | 32 | Instruction on the integer port |
| fp_issue | output | 1 | FP port issues this cycle |
| fp_instr | output | 32 | Instruction on the FP port |
| hold | output | 1 | Younger instruction kept for the next cycle |

## Verification
The assertions check the per-cycle port relations on every cycle. These are: class-correct port use, no issued instruction reading a busy register, no dual issue across a destination conflict, ready low while holding, and never two issues in the cycle after a hold. Whether the right instruction was chosen for a given pair can only be shown by the bench's scenarios. The same goes for the younger one leaving on the cycle after its deferral, a blocked older instruction stopping the whole pair, and the handshake taking the right words. The bench compares every output against a program-order queue model over random pairs with crowded register numbers, plus directed placement, dependence and busy cases.

// File: rtl/pairdec_pkg.sv
// Shared encoding for the dual-issue pair checker.
// Assumes a fixed 32-bit instruction with one class bit and three 5-bit register fields.
package pairdec_pkg;
    localparam int INSTR_W  = 32;
    localparam int REG_W    = 5;
    localparam int NUM_REGS = 1 << REG_W;
    localparam int CLASS_B  = 31;
    localparam int DST_LSB  = 21;
    localparam int SRC1_LSB = 16;
    localparam int SRC2_LSB = 11;
    localparam int SLOTS    = 2;

    typedef struct packed {
        logic             is_fp;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
    } pd_fields_t;
endpackage

// File: rtl/pair_field_dec.sv
// Splits one instruction into class bit and register specifiers.
// Assumes the field layout in pairdec_pkg; purely combinational.
module pair_field_dec
    import pairdec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output pd_fields_t         fields
);
    // Extract class and register numbers
    always_comb begin
        fields.is_fp = instr[CLASS_B];
        fields.dst   = instr[DST_LSB  +: REG_W];
        fields.src1  = instr[SRC1_LSB +: REG_W];
        fields.src2  = instr[SRC2_LSB +: REG_W];
    end
endmodule

// File: rtl/pair_src_free.sv
// Reports whether both source registers of one instruction are free of pending writes.
// Assumes one busy bit per architectural register.
module pair_src_free
    import pairdec_pkg::*;
(
    input  pd_fields_t          fields,
    input  logic [NUM_REGS-1:0] busy,
    output logic                free
);
    // Both sources must be clear
    always_comb begin
        free = !busy[fields.src1] && !busy[fields.src2];
    end
endmodule

// File: rtl/pair_cross_chk.sv
// Detects a dependence of the younger instruction on the older one's destination.
// Covers read-after-write (either source) and write-after-write (destination).
module pair_cross_chk
    import pairdec_pkg::*;
(
    input  pd_fields_t older,
    input  pd_fields_t younger,
    output logic       conflict
);
    // Compare the older destination with all three younger specifiers
    always_comb begin
        conflict = (younger.src1 == older.dst) ||
                   (younger.src2 == older.dst) ||
                   (younger.dst  == older.dst);
    end
endmodule

// File: rtl/dual_issue_pair.sv
// Dual-issue pair checker: latches a two-instruction fetch word and issues the older
// instruction, both, or none each cycle. Dual issue only for non-FP older + FP younger
// with no intra-pair dependence and free sources. Takes a new word only once empty.
module dual_issue_pair
    import pairdec_pkg::*;
#(
    parameter int FETCH_W = SLOTS * INSTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_valid,
    input  logic [FETCH_W-1:0]  fetch_word,
    output logic                fetch_ready,
    input  logic [NUM_REGS-1:0] reg_busy,
    output logic                int_issue,
    output logic [INSTR_W-1:0]  int_instr,
    output logic                fp_issue,
    output logic [INSTR_W-1:0]  fp_instr,
    output logic                hold
);
    logic [INSTR_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]   slot_v;
    pd_fields_t         fld    [SLOTS];
    logic [SLOTS-1:0]   src_ok;
    logic               conflict;
    logic               older_go, younger_go, pair_go, lone_go;
    logic               keep_older, keep_younger, accept;

    // Per-slot decode and source readiness
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        pair_field_dec u_dec (
            .instr  (slot_q[s]),
            .fields (fld[s])
        );
        pair_src_free u_free (
            .fields (fld[s]),
            .busy   (reg_busy),
            .free   (src_ok[s])
        );
    end

    pair_cross_chk u_xchk (
        .older    (fld[0]),
        .younger  (fld[1]),
        .conflict (conflict)
    );

    // Issue decision in program order
    always_comb begin
        older_go     = slot_v[0] && src_ok[0];
        pair_go      = older_go && slot_v[1] && !fld[0].is_fp && fld[1].is_fp
                       && !conflict && src_ok[1];
        lone_go      = !slot_v[0] && slot_v[1] && src_ok[1];
        younger_go   = pair_go || lone_go;
        keep_older   = slot_v[0] && !older_go;
        keep_younger = slot_v[1] && !younger_go;
        fetch_ready  = !keep_older && !keep_younger;
        accept       = fetch_valid && fetch_ready;
        hold         = older_go && slot_v[1] && !younger_go;
    end

    // Route issued instructions to the port matching their class
    always_comb begin
        int_issue = (older_go && !fld[0].is_fp) || (younger_go && !fld[1].is_fp);
        fp_issue  = (older_go &&  fld[0].is_fp) || (younger_go &&  fld[1].is_fp);
        int_instr = (older_go && !fld[0].is_fp) ? slot_q[0] : slot_q[1];
        fp_instr  = (older_go &&  fld[0].is_fp) ? slot_q[0] : slot_q[1];
    end

    // Pair storage: load on accept, otherwise drop what issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= '0;
            for (int s = 0; s < SLOTS; s++) slot_q[s] <= '0;
        end else if (accept) begin
            slot_v <= '1;
            for (int s = 0; s < SLOTS; s++) slot_q[s] <= fetch_word[s*INSTR_W +: INSTR_W];
        end else begin
            slot_v <= {keep_younger, keep_older};
        end
    end
endmodule

// File: rtl/dual_issue_pair_chk.sv
// Port-level checker for dual_issue_pair, attached by bind.
module dual_issue_pair_chk
    import pairdec_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                fetch_ready,
    input logic [NUM_REGS-1:0] reg_busy,
    input logic                int_issue,
    input logic [INSTR_W-1:0]  int_instr,
    input logic                fp_issue,
    input logic [INSTR_W-1:0]  fp_instr,
    input logic                hold
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!int_issue && !fp_issue && fetch_ready)); // R1
    AST_INT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        int_issue |-> !int_instr[CLASS_B]); // R3
    AST_FP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        fp_issue |-> fp_instr[CLASS_B]); // R3
    AST_DUAL_NO_DEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int_issue && fp_issue) |->
            (fp_instr[SRC1_LSB +: REG_W] != int_instr[DST_LSB +: REG_W] &&
             fp_instr[SRC2_LSB +: REG_W] != int_instr[DST_LSB +: REG_W] &&
             fp_instr[DST_LSB  +: REG_W] != int_instr[DST_LSB +: REG_W])); // R6
    AST_INT_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        int_issue |-> (!reg_busy[int_instr[SRC1_LSB +: REG_W]] &&
                       !reg_busy[int_instr[SRC2_LSB +: REG_W]])); // R8
    AST_FP_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        fp_issue |-> (!reg_busy[fp_instr[SRC1_LSB +: REG_W]] &&
                      !reg_busy[fp_instr[SRC2_LSB +: REG_W]])); // R8
    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !fetch_ready); // R10
    AST_HOLD_THEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !(int_issue && fp_issue)); // R9
endmodule

bind dual_issue_pair dual_issue_pair_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_ready (fetch_ready),
    .reg_busy    (reg_busy),
    .int_issue   (int_issue),
    .int_instr   (int_instr),
    .fp_issue    (fp_issue),
    .fp_instr    (fp_instr),
    .hold        (hold)
);

// File: tb/tb_dual_issue_pair.sv
module tb_dual_issue_pair;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_word = '0;
    logic        fetch_ready;
    logic [31:0] reg_busy = '0;
    logic        int_issue, fp_issue, hold;
    logic [31:0] int_instr, fp_instr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int          mn = 0;
    logic [31:0] mq0 = '0, mq1 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_pair dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .fetch_ready(fetch_ready), .reg_busy(reg_busy), .int_issue(int_issue),
        .int_instr(int_instr), .fp_issue(fp_issue), .fp_instr(fp_instr), .hold(hold)
    );

    function automatic logic [31:0] mk(input logic fp, input int d, input int a, input int b);
        return {fp, 5'b01010, d[4:0], a[4:0], b[4:0], 11'h155};
    endfunction

    function automatic logic srcs_free(input logic [31:0] i, input logic [31:0] busy);
        return !busy[i[20:16]] && !busy[i[15:11]];
    endfunction

    function automatic logic depends(input logic [31:0] o, input logic [31:0] y);
        return (y[20:16] == o[25:21]) || (y[15:11] == o[25:21]) || (y[25:21] == o[25:21]);
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check outputs against the queue model, advance the model
    task automatic step(input logic v, input logic [63:0] w, input logic [31:0] busy,
                        input string tag);
        logic e_int, e_fp, e_hold, e_ready;
        logic [31:0] e_ii, e_fi;
        int issued, rem;
        @(negedge clk);
        fetch_valid = v; fetch_word = w; reg_busy = busy;
        #1;
        e_int = 0; e_fp = 0; e_ii = '0; e_fi = '0; issued = 0;
        if (mn >= 1 && srcs_free(mq0, busy)) begin
            issued = 1;
            if (mq0[31]) begin e_fp = 1; e_fi = mq0; end else begin e_int = 1; e_ii = mq0; end
            if (mn == 2 && !mq0[31] && mq1[31] && !depends(mq0, mq1) && srcs_free(mq1, busy)) begin
                issued = 2; e_fp = 1; e_fi = mq1;
            end
        end
        rem = mn - issued;
        e_hold  = (issued == 1 && mn == 2);
        e_ready = (rem == 0);
        chk(int_issue == e_int, tag, "int_issue", {31'b0, int_issue}, {31'b0, e_int});
        chk(fp_issue == e_fp, tag, "fp_issue", {31'b0, fp_issue}, {31'b0, e_fp});
        chk(hold == e_hold, tag, "hold", {31'b0, hold}, {31'b0, e_hold});
        chk(fetch_ready == e_ready, tag, "fetch_ready", {31'b0, fetch_ready}, {31'b0, e_ready});
        if (e_int) chk(int_instr == e_ii, tag, "int_instr", int_instr, e_ii);
        if (e_fp)  chk(fp_instr == e_fi, tag, "fp_instr", fp_instr, e_fi);
        if (issued == 1 && mn == 2) mq0 = mq1;
        mn = rem;
        if (v && e_ready) begin mq0 = w[31:0]; mq1 = w[63:32]; mn = 2; end
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 3; k++) step(1'b0, '0, '0, tag);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <%0d", cycles, MAX_CYCLES);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle after reset
        step(1'b0, '0, '0, "R1");
        // R4 and R2: clean int+fp pair issues together the cycle after acceptance
        step(1'b1, {mk(1, 4, 5, 6), mk(0, 1, 2, 3)}, '0, "R2");
        step(1'b0, '0, '0, "R4");
        // R5: fp older, fp younger -> serialized on FP port
        step(1'b1, {mk(1, 4, 5, 6), mk(1, 1, 2, 3)}, '0, "R5");
        drain("R5");
        // R5: int + int
        step(1'b1, {mk(0, 4, 5, 6), mk(0, 1, 2, 3)}, '0, "R5");
        drain("R5");
        // R5: fp older with int younger
        step(1'b1, {mk(0, 4, 5, 6), mk(1, 1, 2, 3)}, '0, "R5");
        drain("R5");
        // R6: younger reads older destination
        step(1'b1, {mk(1, 4, 7, 6), mk(0, 7, 2, 3)}, '0, "R6");
        drain("R6");
        // R6: younger writes older destination
        step(1'b1, {mk(1, 7, 5, 6), mk(0, 7, 2, 3)}, '0, "R6");
        drain("R6");
        // R8 and R7: older blocked, younger free -> nothing issues, ready low
        step(1'b1, {mk(1, 4, 5, 6), mk(0, 1, 2, 3)}, 32'h0000_0004, "R8");
        step(1'b0, '0, 32'h0000_0004, "R7");
        step(1'b0, '0, 32'h0000_0004, "R8");
        drain("R8");
        // R9 and R10: younger held by busy source, then released
        step(1'b1, {mk(1, 4, 9, 6), mk(0, 1, 2, 3)}, 32'h0000_0200, "R9");
        step(1'b1, {mk(1, 4, 5, 6), mk(0, 1, 2, 3)}, 32'h0000_0200, "R9");
        step(1'b1, {mk(1, 4, 5, 6), mk(0, 1, 2, 3)}, 32'h0000_0200, "R10");
        step(1'b0, '0, '0, "R9");
        drain("R10");
        // R3: random pairs over a crowded register range
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, b, busy;
            a = mk($urandom % 2, $urandom % 4, $urandom % 4, $urandom % 4);
            b = mk($urandom % 2, $urandom % 4, $urandom % 4, $urandom % 4);
            busy = '0;
            for (int r = 0; r < 4; r++) busy[r] = (($urandom % 5) == 0);
            step(($urandom % 4) != 0, {b, a}, busy, "R3");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule